// File: doc/BRIEF.md
# Merging Write Buffer with Read-Miss Bypass

This block sits between a write-through cache and the next memory level. The CPU hands each store to it as a word address plus data. The store counts as finished once the buffer accepts it. The buffer is organised by aligned block. A store to a block that already has a waiting entry goes into that entry, word by word, with a per-word valid mask. Otherwise the store opens a new entry. Entries go to memory oldest first, one block-wide masked write at a time. When every entry is taken and a store cannot merge, the CPU is held off.

A read miss asks for a whole block. It does not wait for the queued stores to drain. At the next free slot on the memory port it goes ahead of them, and the arbiter never aborts a transfer that has already started. When the read data returns, the words that waiting entries hold for that block replace the memory words, and the result goes back to the requester. A store is never merged into the entry that is being written out at that moment; it opens a fresh entry instead.

Top module: `wbuf_top`

## Requirements
- R1: After reset, wr_ready is 1 and both mem_req and rd_done are 0.
- R2: Every store that is accepted (wr_valid and wr_ready high on a rising edge) reaches memory with its address and data. Once the buffer is idle, memory holds the latest accepted value of every word.
- R3: A store merges into the waiting entry for its block (wr_addr bits above the low log2(WORDS) bits) when one exists and that entry is not draining. The drain then covers all merged words in one transfer. mem_wmask bit i marks word offset i, which is the low bits of wr_addr. Word i is carried on mem_wdata bits i*DATA_W and up.
- R4: A store to the block of the entry that is draining does not merge into it. It opens a new entry, which drains later as its own transfer. If no entry is free, the store is stalled (wr_ready 0).
- R5: With DEPTH entries in use, a store that cannot merge sees wr_ready 0. A store that can merge into a non-draining entry still sees wr_ready 1.
- R6: Entries drain one at a time in the order they were opened. Whenever the port is idle and an entry waits with no read pending, a transfer starts on the next cycle.
- R7: When the memory port is idle and rd_req is pending, the next transfer is the read (mem_we 0), even while stores are queued.
- R8: A transfer in flight holds mem_req, mem_we and mem_addr steady until mem_ack. A pending read does not preempt it.
- R9: rd_data equals the memory block, with every word that a waiting entry holds for rd_addr replaced. Newer entries win over older ones.
- R10: rd_done is a one-cycle pulse in the cycle after the read's mem_ack. The requester holds rd_req and rd_addr until then and drops rd_req during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | CPU store request |
| wr_addr | input | BLK_W+log2(WORDS) | Store word address |
| wr_data | input | DATA_W | Store data |
| wr_ready | output | 1 | Store accepted this cycle when high |
| rd_req | input | 1 | Read miss pending, held until rd_done |
| rd_addr | input | BLK_W | Read miss block address |
| rd_done | output | 1 | Read result valid pulse |
| rd_data | output | WORDS*DATA_W | Read result block |
| mem_req | output | 1 | Memory transfer active |
| mem_we | output | 1 | Transfer is a drain write |
| mem_addr | output | BLK_W | Transfer block address |
| mem_wdata | output | WORDS*DATA_W | Drain write data |
| mem_wmask | output | WORDS | Drain word enables |
| mem_ack | input | 1 | Transfer complete pulse |
| mem_rdata | input | WORDS*DATA_W | Read data, valid with mem_ack |

## Verification
The hardest states to reach are those where the drain entry and a newer entry hold the same block, and where a read arrives while a drain is stuck in flight and more stores are queued behind it. The bench gets there by holding back memory acknowledges. While the acknowledges are held, it opens an entry, waits for the drain to start, and then stores to that same block again, fills the buffer, or raises a read. It then releases memory and checks the order, masks and data of the transfers that follow. Random stores and reads over a few blocks, with random memory latency, add merges and conflicts on top.

// File: rtl/wbuf_pkg.sv
`timescale 1ns/1ps
package wbuf_pkg;
   typedef enum logic [1:0] {
      ARB_IDLE  = 2'd0,
      ARB_READ  = 2'd1,
      ARB_DRAIN = 2'd2
   } arb_state_e;
endpackage

// File: rtl/wbuf_store.sv
`timescale 1ns/1ps
module wbuf_store #(
   parameter int DEPTH  = 4,
   parameter int WORDS  = 4,
   parameter int DATA_W = 32,
   parameter int TAG_W  = 8,
   localparam int OFF_W = $clog2(WORDS),
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   wr_valid,
   input  logic [TAG_W-1:0]                       wr_tag,
   input  logic [OFF_W-1:0]                       wr_off,
   input  logic [DATA_W-1:0]                      wr_data,
   input  logic                                   drain_busy,
   input  logic                                   pop,
   output logic                                   wr_ready,
   output logic                                   alloc,
   output logic [DEPTH-1:0]                       hit_vec,
   output logic [CNT_W-1:0]                       count,
   output logic [PTR_W-1:0]                       head,
   output logic [DEPTH-1:0]                       ent_vld,
   output logic [DEPTH-1:0][TAG_W-1:0]            ent_tag,
   output logic [DEPTH-1:0][WORDS-1:0]            ent_mask,
   output logic [DEPTH-1:0][WORDS-1:0][DATA_W-1:0] ent_data
);
   logic [PTR_W-1:0] head_q, tail_q;
   logic [CNT_W-1:0] cnt_q;
   logic             merge, accept;

   for (genvar g = 0; g < DEPTH; g++) begin : g_hit
      assign hit_vec[g] = ent_vld[g] && (ent_tag[g] == wr_tag)
                          && !(drain_busy && (head_q == PTR_W'(g)));
   end

   assign merge    = |hit_vec;
   assign wr_ready = merge || (cnt_q < CNT_W'(DEPTH));
   assign accept   = wr_valid && wr_ready;
   assign alloc    = accept && !merge;

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_vld[g]  <= 1'b0;
            ent_tag[g]  <= '0;
            ent_mask[g] <= '0;
            ent_data[g] <= '0;
         end else if (alloc && (tail_q == PTR_W'(g))) begin
            ent_vld[g]          <= 1'b1;
            ent_tag[g]          <= wr_tag;
            ent_mask[g]         <= WORDS'(1) << wr_off;
            ent_data[g][wr_off] <= wr_data;
         end else if (accept && hit_vec[g]) begin
            ent_mask[g][wr_off] <= 1'b1;
            ent_data[g][wr_off] <= wr_data;
         end else if (pop && (head_q == PTR_W'(g))) begin
            ent_vld[g] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (pop)   head_q <= head_q + PTR_W'(1);
         if (alloc) tail_q <= tail_q + PTR_W'(1);
         cnt_q <= cnt_q + CNT_W'(alloc) - CNT_W'(pop);
      end
   end

   assign count = cnt_q;
   assign head  = head_q;
endmodule

// File: rtl/wbuf_fwd.sv
`timescale 1ns/1ps
module wbuf_fwd #(
   parameter int DEPTH  = 4,
   parameter int WORDS  = 4,
   parameter int DATA_W = 32,
   parameter int TAG_W  = 8,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic [TAG_W-1:0]                        rd_tag,
   input  logic [WORDS-1:0][DATA_W-1:0]            mem_line,
   input  logic [PTR_W-1:0]                        head,
   input  logic [DEPTH-1:0]                        ent_vld,
   input  logic [DEPTH-1:0][TAG_W-1:0]             ent_tag,
   input  logic [DEPTH-1:0][WORDS-1:0]             ent_mask,
   input  logic [DEPTH-1:0][WORDS-1:0][DATA_W-1:0] ent_data,
   output logic [WORDS-1:0][DATA_W-1:0]            line_o
);
   // walk entries from oldest to newest so the newest word lands last
   always_comb begin
      logic [PTR_W-1:0] idx;
      line_o = mem_line;
      idx    = head;
      for (int k = 0; k < DEPTH; k++) begin
         idx = head + PTR_W'(k);
         if (ent_vld[idx] && (ent_tag[idx] == rd_tag)) begin
            for (int w = 0; w < WORDS; w++) begin
               if (ent_mask[idx][w]) line_o[w] = ent_data[idx][w];
            end
         end
      end
   end
endmodule

// File: rtl/wbuf_arb.sv
`timescale 1ns/1ps
module wbuf_arb
   import wbuf_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic rd_req,
   input  logic drain_pending,
   input  logic mem_ack,
   output logic mem_req,
   output logic mem_we,
   output logic drain_busy,
   output logic pop,
   output logic rd_capture,
   output logic rd_done
);
   arb_state_e st_q;
   logic       done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ARB_IDLE;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ARB_IDLE: begin
               if (rd_req && !done_q) st_q <= ARB_READ;
               else if (drain_pending) st_q <= ARB_DRAIN;
            end
            ARB_READ: begin
               if (mem_ack) begin
                  st_q   <= ARB_IDLE;
                  done_q <= 1'b1;
               end
            end
            ARB_DRAIN: begin
               if (mem_ack) st_q <= ARB_IDLE;
            end
            default: st_q <= ARB_IDLE;
         endcase
      end
   end

   assign mem_req    = (st_q != ARB_IDLE);
   assign mem_we     = (st_q == ARB_DRAIN);
   assign drain_busy = (st_q == ARB_DRAIN);
   assign pop        = (st_q == ARB_DRAIN) && mem_ack;
   assign rd_capture = (st_q == ARB_READ) && mem_ack;
   assign rd_done    = done_q;
endmodule

// File: rtl/wbuf_top.sv
`timescale 1ns/1ps
module wbuf_top #(
   parameter int DATA_W = 32,
   parameter int WORDS  = 4,
   parameter int DEPTH  = 4,
   parameter int BLK_W  = 8,
   localparam int OFF_W  = $clog2(WORDS),
   localparam int ADDR_W = BLK_W + OFF_W,
   localparam int LINE_W = WORDS * DATA_W,
   localparam int PTR_W  = $clog2(DEPTH),
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ready,
   input  logic              rd_req,
   input  logic [BLK_W-1:0]  rd_addr,
   output logic              rd_done,
   output logic [LINE_W-1:0] rd_data,
   output logic              mem_req,
   output logic              mem_we,
   output logic [BLK_W-1:0]  mem_addr,
   output logic [LINE_W-1:0] mem_wdata,
   output logic [WORDS-1:0]  mem_wmask,
   input  logic              mem_ack,
   input  logic [LINE_W-1:0] mem_rdata
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("wbuf_top: DEPTH must be a power of two, at least 2");
   end
   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
      $error("wbuf_top: WORDS must be a power of two, at least 2");
   end
   if (DATA_W < 1 || BLK_W < 1) begin : g_bad_width
      $error("wbuf_top: DATA_W and BLK_W must be positive");
   end

   logic                                   drain_busy, pop, rd_capture;
   logic                                   ent_alloc;
   logic [DEPTH-1:0]                       ent_hit;
   logic [CNT_W-1:0]                       ent_cnt;
   logic [PTR_W-1:0]                       ent_head;
   logic [DEPTH-1:0]                       ent_vld;
   logic [DEPTH-1:0][BLK_W-1:0]            ent_tag;
   logic [DEPTH-1:0][WORDS-1:0]            ent_mask;
   logic [DEPTH-1:0][WORDS-1:0][DATA_W-1:0] ent_data;
   logic [WORDS-1:0][DATA_W-1:0]           fwd_line;
   logic [LINE_W-1:0]                      rd_data_q;

   wbuf_store #(.DEPTH(DEPTH), .WORDS(WORDS), .DATA_W(DATA_W), .TAG_W(BLK_W)) i_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_valid   (wr_valid),
      .wr_tag     (wr_addr[ADDR_W-1:OFF_W]),
      .wr_off     (wr_addr[OFF_W-1:0]),
      .wr_data    (wr_data),
      .drain_busy (drain_busy),
      .pop        (pop),
      .wr_ready   (wr_ready),
      .alloc      (ent_alloc),
      .hit_vec    (ent_hit),
      .count      (ent_cnt),
      .head       (ent_head),
      .ent_vld    (ent_vld),
      .ent_tag    (ent_tag),
      .ent_mask   (ent_mask),
      .ent_data   (ent_data)
   );

   wbuf_arb i_arb (
      .clk           (clk),
      .rst_n         (rst_n),
      .rd_req        (rd_req),
      .drain_pending (ent_cnt != '0),
      .mem_ack       (mem_ack),
      .mem_req       (mem_req),
      .mem_we        (mem_we),
      .drain_busy    (drain_busy),
      .pop           (pop),
      .rd_capture    (rd_capture),
      .rd_done       (rd_done)
   );

   wbuf_fwd #(.DEPTH(DEPTH), .WORDS(WORDS), .DATA_W(DATA_W), .TAG_W(BLK_W)) i_fwd (
      .rd_tag   (rd_addr),
      .mem_line (mem_rdata),
      .head     (ent_head),
      .ent_vld  (ent_vld),
      .ent_tag  (ent_tag),
      .ent_mask (ent_mask),
      .ent_data (ent_data),
      .line_o   (fwd_line)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)          rd_data_q <= '0;
      else if (rd_capture) rd_data_q <= fwd_line;
   end

   assign rd_data   = rd_data_q;
   assign mem_addr  = mem_we ? ent_tag[ent_head] : rd_addr;
   assign mem_wdata = ent_data[ent_head];
   assign mem_wmask = ent_mask[ent_head];
endmodule

// File: rtl/wbuf_checker.sv
`timescale 1ns/1ps
module wbuf_checker #(
   parameter int DEPTH = 4,
   parameter int BLK_W = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rd_req,
   input logic             rd_done,
   input logic             mem_req,
   input logic             mem_we,
   input logic             mem_ack,
   input logic [BLK_W-1:0] mem_addr,
   input logic [CNT_W-1:0] cnt,
   input logic             alloc,
   input logic [DEPTH-1:0] hit_vec
);
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) int'(cnt) <= DEPTH); // R5
   AST_SINGLE_MERGE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec)); // R3
   AST_HOLD_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr)); // R8
   AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_req && rd_req && !rd_done |=> mem_req && !mem_we); // R7
   AST_DRAIN_POP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ack && mem_we |=> int'(cnt) + 1 == int'($past(cnt)) + int'($past(alloc))); // R6
   AST_NO_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_req && cnt != '0 |=> mem_req); // R6
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rd_done |=> !rd_done); // R10
   AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_done) |-> $past(mem_ack && mem_req && !mem_we)); // R10
endmodule

bind wbuf_top wbuf_checker #(.DEPTH(DEPTH), .BLK_W(BLK_W)) i_wbuf_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_req   (rd_req),
   .rd_done  (rd_done),
   .mem_req  (mem_req),
   .mem_we   (mem_we),
   .mem_ack  (mem_ack),
   .mem_addr (mem_addr),
   .cnt      (ent_cnt),
   .alloc    (ent_alloc),
   .hit_vec  (ent_hit)
);

// File: tb/test_wbuf_top.sv
`timescale 1ns/100ps
module test_wbuf_top;
   localparam int DW = 32;
   localparam int NW = 4;
   localparam int BW = 8;
   localparam int OW = 2;
   localparam int LW = NW * DW;
   localparam int NB = 256;
   localparam int LOGN = 2048;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_valid = 1'b0;
   logic [BW+OW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          wr_ready;
   logic          rd_req = 1'b0;
   logic [BW-1:0] rd_addr = '0;
   logic          rd_done;
   logic [LW-1:0] rd_data;
   logic          mem_req, mem_we;
   logic [BW-1:0] mem_addr;
   logic [LW-1:0] mem_wdata;
   logic [NW-1:0] mem_wmask;
   logic          mem_ack = 1'b0;
   logic [LW-1:0] mem_rdata = '0;

   wbuf_top i_wbuf_top (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_ready(wr_ready), .rd_req(rd_req), .rd_addr(rd_addr), .rd_done(rd_done),
      .rd_data(rd_data), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_wmask(mem_wmask), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   always #2 clk = ~clk;

   logic [DW-1:0] bmem [NB][NW];
   logic [DW-1:0] rmem [NB][NW];
   logic          log_we   [LOGN];
   logic [BW-1:0] log_blk  [LOGN];
   logic [NW-1:0] log_mask [LOGN];
   logic [LW-1:0] log_data [LOGN];
   int            log_n = 0;
   bit            hold = 1'b0;
   int            lat_max = 2;
   int            lat_cnt = 0;
   int            n_cmp = 0;
   int            n_bad = 0;
   logic [LW-1:0] rd_exp;
   int            rd_n0;
   int            rd_infl;
   int            rd_blk;

   function automatic logic [DW-1:0] init_word(input int b, input int w);
      return 32'hC0DE_0000 ^ DW'(b * 16 + w);
   endfunction

   function automatic logic [LW-1:0] ref_line(input int b);
      logic [LW-1:0] l;
      for (int w = 0; w < NW; w++) l[w*DW +: DW] = rmem[b][w];
      return l;
   endfunction

   // memory model: acks after a random latency unless held
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_ack = 1'b0;
         lat_cnt = 0;
      end else if (mem_ack) begin
         mem_ack = 1'b0;
      end else if (mem_req && !hold) begin
         if (lat_cnt > 0) lat_cnt--;
         else begin
            if (mem_we) begin
               for (int w = 0; w < NW; w++)
                  if (mem_wmask[w]) bmem[mem_addr][w] = mem_wdata[w*DW +: DW];
            end else begin
               for (int w = 0; w < NW; w++) mem_rdata[w*DW +: DW] = bmem[mem_addr][w];
            end
            if (log_n < LOGN) begin
               log_we[log_n]   = mem_we;
               log_blk[log_n]  = mem_addr;
               log_mask[log_n] = mem_wmask;
               log_data[log_n] = mem_wdata;
               log_n++;
            end
            mem_ack = 1'b1;
            lat_cnt = $urandom_range(lat_max, 0);
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_wr(input int b, input int w, input logic [DW-1:0] d);
      @(negedge clk); #0.5;
      wr_valid = 1'b1;
      wr_addr  = {BW'(b), OW'(w)};
      wr_data  = d;
      #0.5;
      while (!wr_ready) begin
         @(negedge clk); #1;
      end
      rmem[b][w] = d;
      @(posedge clk); #0.5;
      wr_valid = 1'b0;
   endtask

   task automatic probe_wr(input int b, input int w, input bit exp_rdy, input string req);
      @(negedge clk); #0.5;
      wr_valid = 1'b1;
      wr_addr  = {BW'(b), OW'(w)};
      wr_data  = 32'hDEAD_BEEF;
      #0.5;
      chk(wr_ready == exp_rdy, req, LW'(wr_ready), LW'(exp_rdy));
      #0.2;
      wr_valid = 1'b0;
   endtask

   task automatic start_read(input int b);
      @(negedge clk); #0.5;
      rd_blk  = b;
      rd_exp  = ref_line(b);
      rd_n0   = log_n;
      rd_infl = (mem_req && mem_we && !mem_ack) ? 1 : 0;
      rd_req  = 1'b1;
      rd_addr = BW'(b);
   endtask

   task automatic finish_read();
      int idx;
      do @(negedge clk); while (!rd_done);
      chk(rd_data == rd_exp, "R9 read data with forwarded words", rd_data, rd_exp);
      #0.5;
      rd_req = 1'b0;
      idx = rd_n0 + rd_infl;
      chk(!log_we[idx] && log_blk[idx] == BW'(rd_blk), "R7 read overtakes queued drains",
          LW'({log_we[idx], log_blk[idx]}), LW'(rd_blk));
      @(negedge clk);
      chk(!rd_done, "R10 done is a single pulse", LW'(rd_done), '0);
   endtask

   task automatic do_summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      do_summary();
      $finish;
   end

   initial begin
      int base;
      logic [LW-1:0] ydat;
      void'($urandom(32'd4711));
      for (int b = 0; b < NB; b++)
         for (int w = 0; w < NW; w++) begin
            bmem[b][w] = init_word(b, w);
            rmem[b][w] = init_word(b, w);
         end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1 reset state
      chk(wr_ready == 1'b1, "R1 wr_ready after reset", LW'(wr_ready), LW'(1));
      chk(mem_req == 1'b0, "R1 mem_req after reset", LW'(mem_req), '0);
      chk(rd_done == 1'b0, "R1 rd_done after reset", LW'(rd_done), '0);

      // merge and refused merge into draining entry (R3, R4, R6)
      hold = 1'b1;
      base = log_n;
      do_wr(2, 0, 32'h1111_0000);
      repeat (3) @(negedge clk);
      for (int w = 0; w < NW; w++) begin
         do_wr(3, w, 32'h3300_0000 + DW'(w));
         ydat[w*DW +: DW] = 32'h3300_0000 + DW'(w);
      end
      do_wr(2, 1, 32'h1111_0001);
      hold = 1'b0;
      repeat (40) @(negedge clk);
      chk(log_n == base + 3, "R6 three drains", LW'(log_n - base), LW'(3));
      chk(log_blk[base] == 2 && log_mask[base] == 4'b0001, "R4 first drain of block 2",
          LW'({log_blk[base], log_mask[base]}), LW'({8'd2, 4'b0001}));
      chk(log_blk[base+1] == 3 && log_mask[base+1] == 4'b1111, "R3 merged block 3",
          LW'({log_blk[base+1], log_mask[base+1]}), LW'({8'd3, 4'b1111}));
      chk(log_data[base+1] == ydat, "R3 merged block 3 data", log_data[base+1], ydat);
      chk(log_blk[base+2] == 2 && log_mask[base+2] == 4'b0010, "R4 second entry for block 2",
          LW'({log_blk[base+2], log_mask[base+2]}), LW'({8'd2, 4'b0010}));

      // full buffer stall (R5, R4, R6)
      hold = 1'b1;
      base = log_n;
      do_wr(10, 0, 32'hA000_0000);
      repeat (3) @(negedge clk);
      do_wr(11, 0, 32'hB000_0000);
      do_wr(12, 0, 32'hC000_0000);
      do_wr(13, 0, 32'hD000_0000);
      probe_wr(14, 0, 1'b0, "R5 new block stalls when full");
      probe_wr(11, 1, 1'b1, "R5 merge accepted when full");
      do_wr(11, 1, 32'hB000_0001);
      probe_wr(10, 2, 1'b0, "R4 no merge into draining entry");
      hold = 1'b0;
      repeat (60) @(negedge clk);
      chk(log_blk[base] == 10 && log_blk[base+1] == 11 && log_blk[base+2] == 12 && log_blk[base+3] == 13,
          "R6 drain order", LW'({log_blk[base], log_blk[base+1], log_blk[base+2], log_blk[base+3]}),
          LW'({8'd10, 8'd11, 8'd12, 8'd13}));
      chk(log_mask[base+1] == 4'b0011, "R3 merge while full", LW'(log_mask[base+1]), LW'(4'b0011));

      // read with match while a drain is stuck in flight (R8, R7, R9)
      hold = 1'b1;
      do_wr(20, 0, 32'h2020_0000);
      repeat (3) @(negedge clk);
      do_wr(21, 1, 32'h2121_0001);
      do_wr(21, 3, 32'h2121_0003);
      start_read(21);
      chk(rd_infl == 1, "R8 drain in flight at read request", LW'(rd_infl), LW'(1));
      for (int c = 0; c < 3; c++) begin
         @(negedge clk); #1;
         chk(mem_req && mem_we && mem_addr == 8'd20 && !rd_done, "R8 in-flight drain not preempted",
             LW'({mem_req, mem_we, mem_addr}), LW'({1'b1, 1'b1, 8'd20}));
      end
      hold = 1'b0;
      finish_read();

      // read without match ahead of queued drains (R7, R9)
      hold = 1'b1;
      do_wr(30, 0, 32'h3030_0000);
      repeat (3) @(negedge clk);
      do_wr(31, 2, 32'h3131_0002);
      start_read(32);
      repeat (2) @(negedge clk);
      hold = 1'b0;
      finish_read();

      // random mix over a few blocks
      lat_max = 5;
      for (int i = 0; i < 300; i++) begin
         int b;
         b = int'($urandom_range(7, 0));
         if ($urandom_range(3, 0) == 0) begin
            start_read(b);
            finish_read();
         end else begin
            do_wr(b, int'($urandom_range(NW - 1, 0)), $urandom());
         end
      end

      repeat (200) @(negedge clk);
      for (int b = 0; b < 40; b++) begin
         logic [LW-1:0] got;
         for (int w = 0; w < NW; w++) got[w*DW +: DW] = bmem[b][w];
         chk(got == ref_line(b), "R2 memory holds all accepted stores", got, ref_line(b));
      end
      chk(!mem_req && wr_ready, "R6 buffer drained to idle", LW'({mem_req, wr_ready}), LW'(2'b01));
      do_summary();
      $finish;
   end
endmodule